// File: doc/BRIEF.md
# Parallel Port Extended Control Register with Service Interrupts

This block holds the extended control register of an enhanced-capability parallel port and produces the interrupt and DMA-enable signals that go with it. It sits beside a byte FIFO that lives elsewhere. It takes four inputs from that FIFO side: the FIFO occupancy, an empty indication, the transfer direction and a DMA terminal-count strobe. It also takes two programmable thresholds. The CPU writes the register through a simple strobe-and-data port and reads it back at any time.

The register has six parts: a three-bit operating-mode field, a mask for the fault interrupt, a DMA enable, a service flag, a live full flag and a live empty flag. The service flag works both ways. Software clears it to arm the service interrupt. Hardware sets it again when the armed event happens. Which event is armed depends on the DMA enable and the direction:

- DMA terminal count when DMA is enabled.
- Free FIFO space reaching the write threshold when DMA is off and the direction is 0.
- Stored bytes reaching the read threshold when DMA is off and the direction is 1.

In the enhanced mode, a falling edge on the asynchronous fault pin raises an interrupt. The fault pin passes through a two-flop synchronizer before edge detection. Clearing the fault mask while the fault pin is already low also raises an interrupt, so a fault that arrives between a read and a write of the register is not lost.

Top module: `ecp_ext_ctrl`

## Requirements
- R1: After reset, `reg_rdata[7:2]` reads 000101. This is mode 000, mask 1, DMA 0 and service flag 1. `dma_en` and `irq` are 0.
- R2: A write with `reg_wr` high loads `reg_wdata[7:5]` into the mode field, bit 4 into the fault mask, bit 3 into the DMA enable and bit 2 into the service flag. Bits 1 and 0 of a write have no effect.
- R3: `reg_rdata[1]` reads 1 exactly when `fifo_level` equals the FIFO depth (16 by default). `reg_rdata[0]` follows `fifo_empty`.
- R4: When the mode field is 011 and the mask (bit 4) is 0, each falling edge of `fault_n` gives one `irq` pulse of one cycle. No pulse comes from a rising edge, from a masked edge or from any other mode.
- R5: A write that clears the mask from 1 to 0 while `fault_n` is low and `reg_wdata[7:5]` is 011 gives one `irq` pulse.
- R6: `dma_en` is high exactly when bit 3 is 1 and bit 2 is 0. Writing bit 3 as 0 drops it.
- R7: With bit 3 = 1 and bit 2 = 0, a `dma_tc` pulse gives one `irq` pulse and sets bit 2 to 1, which drops `dma_en`.
- R8: With bit 3 = 0, bit 2 = 0 and `dir` = 0, free space (depth minus `fifo_level`) at or above `wr_thresh` gives one `irq` pulse and sets bit 2. `dma_tc` is then ignored.
- R9: With bit 3 = 0, bit 2 = 0 and `dir` = 1, `fifo_level` at or above `rd_thresh` gives one `irq` pulse and sets bit 2.
- R10: While bit 2 is 1, no service event causes an interrupt, and writing bit 2 as 1 causes none. If software clears bit 2 while the armed condition still holds, the interrupt fires again.
- R11: If a service event and a CPU write fall in the same cycle, the hardware set of bit 2 wins over a written 0. Exactly one `irq` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| fault_n | input | 1 | Asynchronous active-low fault pin |
| fifo_level | input | LVL_W (5) | Bytes held in the FIFO |
| fifo_empty | input | 1 | FIFO empty indication |
| dir | input | 1 | Transfer direction, 1 = toward host |
| wr_thresh | input | LVL_W (5) | Free-space threshold |
| rd_thresh | input | LVL_W (5) | Stored-byte threshold |
| dma_tc | input | 1 | DMA terminal-count strobe |
| dma_en | output | 1 | Effective DMA enable |
| irq | output | 1 | Interrupt pulse |

## Verification
The risky overlap is a CPU write of the register landing in the same cycle as a service event. Software clears the service flag while hardware wants to set it. The bench clears the flag with no event pending. It then asserts a write of 0 to bit 2 on the same clock edge as an occupancy change that crosses the read threshold. It requires a single interrupt pulse and bit 2 reading 1 afterwards. A design where the write won would show a second pulse on the following cycle.

// File: rtl/ecp_ctrl_pkg.sv
package ecp_ctrl_pkg;

  localparam int MODE_W   = 3;
  localparam int REG_W    = 8;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              fault_mask;
    logic              dma_on;
    logic              svc_flag;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{mode: '0, fault_mask: 1'b1, dma_on: 1'b0, svc_flag: 1'b1};

  localparam int B_MASK = 4;
  localparam int B_DMA  = 3;
  localparam int B_SVC  = 2;
  localparam int B_FULL = 1;

endpackage

// File: rtl/ecp_rst_sync.sv
module ecp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[STAGES-1];

endmodule

// File: rtl/ecp_fault_edge.sv
module ecp_fault_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic fault_n_i,
  output logic fault_low_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = fault_n_i;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], fault_n_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fault_low_o = ~sync_q[STAGES-1];
  assign fall_o      = prev_q & ~sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_ns)
    fall_o |=> !fall_o); // R4

endmodule

// File: rtl/ecp_svc_sel.sv
module ecp_svc_sel #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             dma_on_i,
  input  logic             dir_i,
  input  logic             flag_i,
  input  logic             dma_tc_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] wr_thr_i,
  input  logic [LVL_W-1:0] rd_thr_i,
  output logic             evt_o,
  output logic             hit_o
);

  localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(FIFO_DEPTH);

  logic [LVL_W-1:0] free_w;
  logic             space_ok;
  logic             data_ok;

  always_comb begin
    free_w   = DEPTH_V - level_i;
    space_ok = (free_w >= wr_thr_i);
    data_ok  = (level_i >= rd_thr_i);
    if (dma_on_i)   evt_o = dma_tc_i;
    else if (dir_i) evt_o = data_ok;
    else            evt_o = space_ok;
    hit_o = evt_o & ~flag_i;
  end

endmodule

// File: rtl/ecp_ext_ctrl.sv
module ecp_ext_ctrl #(
  parameter int             FIFO_DEPTH  = 16,
  parameter int             LVL_W       = $clog2(FIFO_DEPTH + 1),
  parameter int             SYNC_STAGES = 2,
  parameter logic [2:0]     ECP_MODE    = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             fault_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_empty,
  input  logic             dir,
  input  logic [LVL_W-1:0] wr_thresh,
  input  logic [LVL_W-1:0] rd_thresh,
  input  logic             dma_tc,
  output logic             dma_en,
  output logic             irq
);

  import ecp_ctrl_pkg::*;

  localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(FIFO_DEPTH);

  logic rst_ns;
  logic fault_low;
  logic fall_w;
  logic svc_evt;
  logic svc_hit;

  ctl_t ctl_q, ctl_d;
  logic ctl_en;
  logic irq_q, irq_d;
  logic edge_irq;
  logic rearm_irq;
  logic full_w;

  ecp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  ecp_fault_edge #(.STAGES(SYNC_STAGES)) u_fault (
    .clk         (clk),
    .rst_ns      (rst_ns),
    .fault_n_i   (fault_n),
    .fault_low_o (fault_low),
    .fall_o      (fall_w)
  );

  ecp_svc_sel #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_svc (
    .dma_on_i (ctl_q.dma_on),
    .dir_i    (dir),
    .flag_i   (ctl_q.svc_flag),
    .dma_tc_i (dma_tc),
    .level_i  (fifo_level),
    .wr_thr_i (wr_thresh),
    .rd_thr_i (rd_thresh),
    .evt_o    (svc_evt),
    .hit_o    (svc_hit)
  );

  // Next-state logic: CPU write first, hardware set of the service flag on top
  always_comb begin
    ctl_d = ctl_q;
    if (reg_wr) begin
      ctl_d.mode       = reg_wdata[7:5];
      ctl_d.fault_mask = reg_wdata[B_MASK];
      ctl_d.dma_on     = reg_wdata[B_DMA];
      ctl_d.svc_flag   = reg_wdata[B_SVC];
    end
    if (svc_hit) ctl_d.svc_flag = 1'b1;
    ctl_en = reg_wr | svc_hit;

    edge_irq  = fall_w & (ctl_q.mode == ECP_MODE) & ~ctl_q.fault_mask;
    rearm_irq = reg_wr & ctl_q.fault_mask & ~reg_wdata[B_MASK]
              & (reg_wdata[7:5] == ECP_MODE) & fault_low;
    irq_d     = svc_hit | edge_irq | rearm_irq;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctl_q <= CTL_RESET;
      irq_q <= 1'b0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      irq_q <= irq_d;
    end
  end

  assign full_w    = (fifo_level == DEPTH_V);
  assign reg_rdata = {ctl_q.mode, ctl_q.fault_mask, ctl_q.dma_on, ctl_q.svc_flag, full_w, fifo_empty};
  assign dma_en    = ctl_q.dma_on & ~ctl_q.svc_flag;
  assign irq       = irq_q;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr && !svc_hit) |=> (reg_rdata[7:2] == $past(reg_wdata[7:2]))); // R2

  AST_FULL_READS: assert property (@(posedge clk) disable iff (!rst_ns)
    (fifo_level == DEPTH_V) |-> reg_rdata[B_FULL]); // R3

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_rdata[B_MASK] && !reg_wr && !svc_hit) |=> !irq); // R4

  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_ns)
    reg_rdata[B_SVC] |-> !dma_en); // R6

  AST_SVC_SETS: assert property (@(posedge clk) disable iff (!rst_ns)
    svc_hit |=> (irq && reg_rdata[B_SVC])); // R7

  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_rdata[B_SVC] && !fall_w && !reg_wr) |=> !irq); // R10

endmodule

// File: tb/ecp_ext_ctrl_tb_top.sv
module ecp_ext_ctrl_tb_top;

  localparam int LW = 5;

  typedef struct packed {
    logic [7:0]    wr;
    logic          dr;
    logic [LW-1:0] lvl;
    logic [LW-1:0] wthr;
    logic [LW-1:0] rthr;
    logic [7:0]    exp;
    logic [1:0]    nirq;
  } vec_t;

  // Mode field kept away from 011 so the fault path stays quiet.
  localparam vec_t VECS [9] = '{
    '{8'h37, 1'b0, 5'd4,  5'd8,  5'd8,  8'h34, 2'd0},  // R2 low bits ignored, R10 flag held
    '{8'h30, 1'b0, 5'd4,  5'd8,  5'd8,  8'h34, 2'd1},  // R8 free 12 >= 8
    '{8'h30, 1'b0, 5'd12, 5'd8,  5'd8,  8'h30, 2'd0},  // R8 free 4 < 8
    '{8'h30, 1'b1, 5'd11, 5'd8,  5'd12, 8'h30, 2'd0},  // R9 11 < 12
    '{8'h30, 1'b1, 5'd12, 5'd8,  5'd12, 8'h34, 2'd2},  // R9 fires, R10 refires on clear
    '{8'h30, 1'b1, 5'd16, 5'd8,  5'd12, 8'h36, 2'd1},  // R3 full, R9
    '{8'h58, 1'b0, 5'd0,  5'd8,  5'd12, 8'h59, 2'd0},  // R6 dma on, R3 empty
    '{8'h50, 1'b0, 5'd0,  5'd16, 5'd12, 8'h55, 2'd1},  // R8 free 16 >= 16
    '{8'h5F, 1'b1, 5'd5,  5'd16, 5'd1,  8'h5C, 2'd0}   // R10 write 1 no irq, R6
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          fault_n;
  logic [LW-1:0] fifo_level;
  logic          fifo_empty;
  logic          dir;
  logic [LW-1:0] wr_thresh;
  logic [LW-1:0] rd_thresh;
  logic          dma_tc;
  logic          dma_en;
  logic          irq;

  int n_run  = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int base;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecp_ext_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .fault_n    (fault_n),
    .fifo_level (fifo_level),
    .fifo_empty (fifo_empty),
    .dir        (dir),
    .wr_thresh  (wr_thresh),
    .rd_thresh  (rd_thresh),
    .dma_tc     (dma_tc),
    .dma_en     (dma_en),
    .irq        (irq)
  );

  always @(negedge clk) if (irq === 1'b1) irq_cnt++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fifo(input logic [LW-1:0] l);
    fifo_level = l;
    fifo_empty = (l == 0);
  endtask

  task automatic tc_pulse();
    @(negedge clk);
    dma_tc = 1'b1;
    @(negedge clk);
    dma_tc = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; fault_n = 1'b1;
    dir = 1'b0; wr_thresh = 5'd8; rd_thresh = 5'd8; dma_tc = 1'b0;
    set_fifo(5'd0);
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 rdata", reg_rdata, 8'h15);
    check("R1 dma_en", {7'd0, dma_en}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    foreach (VECS[i]) begin
      @(negedge clk);
      base = irq_cnt;
      set_fifo(VECS[i].lvl);
      dir = VECS[i].dr;
      wr_thresh = VECS[i].wthr;
      rd_thresh = VECS[i].rthr;
      wr_reg(VECS[i].wr);
      idle(4);
      check("R2 table rdata", reg_rdata, VECS[i].exp);
      check("R6 table dma_en", {7'd0, dma_en}, {7'd0, VECS[i].exp[3] & ~VECS[i].exp[2]});
      check("R8 R9 table irq count", 8'(irq_cnt - base), {6'd0, VECS[i].nirq});
    end

    // R7: terminal count with DMA armed
    set_fifo(5'd4); dir = 1'b0; wr_thresh = 5'd16;
    wr_reg(8'h78);
    idle(2);
    check("R6 dma_en on", {7'd0, dma_en}, 8'h01);
    base = irq_cnt;
    tc_pulse();
    idle(4);
    check("R7 irq count", 8'(irq_cnt - base), 8'd1);
    check("R7 flag set", reg_rdata, 8'h7C);
    check("R7 dma_en dropped", {7'd0, dma_en}, 8'h00);

    // R6/R8: DMA off, terminal count is not the armed source
    wr_reg(8'h70);
    idle(2);
    check("R6 dma_en off", {7'd0, dma_en}, 8'h00);
    base = irq_cnt;
    tc_pulse();
    idle(4);
    check("R8 tc ignored", 8'(irq_cnt - base), 8'd0);
    check("R8 flag clear", reg_rdata, 8'h70);

    // R4: fault edge in enhanced mode
    wr_reg(8'h64);
    idle(2);
    base = irq_cnt;
    fault_n = 1'b0;
    idle(6);
    check("R4 falling edge", 8'(irq_cnt - base), 8'd1);
    base = irq_cnt;
    fault_n = 1'b1;
    idle(6);
    check("R4 rising edge", 8'(irq_cnt - base), 8'd0);
    wr_reg(8'h74);
    base = irq_cnt;
    fault_n = 1'b0;
    idle(6);
    check("R4 masked edge", 8'(irq_cnt - base), 8'd0);

    // R5: clearing the mask with the fault already low
    base = irq_cnt;
    wr_reg(8'h64);
    idle(4);
    check("R5 rearm pulse", 8'(irq_cnt - base), 8'd1);
    check("R5 rdata", reg_rdata, 8'h64);

    // R4/R5 outside enhanced mode
    base = irq_cnt;
    wr_reg(8'h34);
    wr_reg(8'h24);
    idle(3);
    fault_n = 1'b1;
    idle(6);
    fault_n = 1'b0;
    idle(6);
    check("R4 other mode", 8'(irq_cnt - base), 8'd0);

    // R11: write clearing the flag coincides with a service event
    fault_n = 1'b1;
    idle(6);
    dir = 1'b1; rd_thresh = 5'd4; set_fifo(5'd0);
    base = irq_cnt;
    wr_reg(8'h30);
    idle(3);
    check("R11 setup quiet", 8'(irq_cnt - base), 8'd0);
    check("R11 setup rdata", reg_rdata, 8'h31);
    base = irq_cnt;
    @(negedge clk);
    set_fifo(5'd8);
    reg_wr = 1'b1;
    reg_wdata = 8'h30;
    @(negedge clk);
    reg_wr = 1'b0;
    idle(4);
    check("R11 single pulse", 8'(irq_cnt - base), 8'd1);
    check("R11 flag wins", reg_rdata, 8'h34);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule